// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block sits between a processor's memory decoder and a DRAM with a multiplexed address bus. A request pulse (the decoder's chip-select already qualified by the memory/IO line) arrives together with a 16-bit address. The block puts the upper half on the 8-bit DRAM address pins while it lowers the row strobe, switches a multiplexer to the lower half one clock later, and lowers the column strobe one clock after that. The row strobe, the multiplexer select and the column strobe are successive stages of one clocked shift chain, which sits cleared (both strobes inactive) whenever no access runs.

A free-running timer asks for a row-only refresh cycle at a fixed period. During a refresh the row strobe is pulsed with an internal 8-bit row counter on the address pins and the column strobe stays high. A refresh that falls due during an access waits for that access to end. A request that arrives while a refresh runs, or in the same cycle a refresh starts, is held, and `ready` stays low until the held access starts.

Top module: `dram_addr_seq`

## Requirements
- R1: After reset, `ras_n` and `cas_n` are 1 and `ready` is 1.
- R2: A request accepted in an idle cycle lowers `ras_n` at that clock edge, and `dram_addr` then carries `addr[15:8]`.
- R3: One edge after `ras_n` falls, `dram_addr` changes to `addr[7:0]` while `cas_n` is still 1.
- R4: `cas_n` falls one edge after the column switch, stays low for CAS_HOLD cycles with `dram_addr` unchanged, and then `ras_n` and `cas_n` rise at the same edge.
- R5: A request that arrives while an access runs has no effect: the running access keeps its address and no second access follows.
- R6: A refresh starts every REF_PERIOD cycles. It holds `ras_n` low for REF_RAS cycles with `cas_n` high, and drives a row counter on `dram_addr`. The counter is 0 after reset and grows by one with each refresh.
- R7: A refresh that falls due during an access starts one edge after the access has raised its strobes.
- R8: A request taken during a refresh lowers `ready` at the following edge. The held access starts, with the held address, one edge after the refresh raises `ras_n`, and `ready` returns to 1 at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | One-cycle access request from the qualified decoder |
| addr | input | 16 | Access address, sampled with `req` |
| ready | output | 1 | Low while a request is held off by refresh |
| dram_addr | output | 8 | Multiplexed row/column address to the DRAM |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |

## Verification
Counting from the edge that samples `req`, the row address and the low `ras_n` are due at that same edge, the column address one edge later, and `cas_n` low two edges later. Both strobes are due high at edge 2+CAS_HOLD. A refresh holds `ras_n` low for REF_RAS edges, and a held access starts at the next edge. The bench drives and samples on the falling clock edge, so each value it reads settles after exactly the number of rising edges counted above. It checks each value on that exact sample.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_REF  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic ack,
  output logic due
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      due <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      due <= wrap | (due & ~ack);
    end
  end
endmodule

// File: rtl/dram_strobe_chain.sv
module dram_strobe_chain #(
  parameter int CAS_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ras_act,
  output logic col_sel,
  output logic cas_act,
  output logic done
);
  localparam int HW = $clog2(CAS_HOLD + 1);

  logic [2:0]    stage;
  logic [HW-1:0] hold;

  assign ras_act = stage[0];
  assign col_sel = stage[1];
  assign cas_act = stage[2];
  assign done    = stage[2] && (hold == HW'(CAS_HOLD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      hold  <= '0;
    end else if (start) begin
      stage <= 3'b001;
      hold  <= '0;
    end else if (done) begin
      stage <= '0;
      hold  <= '0;
    end else if (stage[0]) begin
      stage <= {stage[1:0], 1'b1};
      if (stage[2]) hold <= hold + 1'b1;
    end
  end
endmodule

// File: rtl/dram_addr_seq.sv
module dram_addr_seq #(
  parameter int ROW_W      = 8,
  parameter int REF_PERIOD = 64,
  parameter int REF_RAS    = 3,
  parameter int CAS_HOLD   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [2*ROW_W-1:0] addr,
  output logic               ready,
  output logic [ROW_W-1:0]   dram_addr,
  output logic               ras_n,
  output logic               cas_n
);
  import dram_seq_pkg::*;

  localparam int AW = 2 * ROW_W;
  localparam int RW = $clog2(REF_RAS + 1);

  seq_state_t      state;
  logic [AW-1:0]   cap;
  logic            pend;
  logic            rdy_q;
  logic            ref_ras;
  logic [RW-1:0]   ref_cnt;
  logic [ROW_W-1:0] row_cnt;

  logic ref_due, ref_ack;
  logic ch_start, ch_ras, ch_sel, ch_cas, ch_done;

  dram_refresh_timer #(.PERIOD(REF_PERIOD)) u_timer (
    .clk(clk), .rst(rst), .ack(ref_ack), .due(ref_due)
  );

  dram_strobe_chain #(.CAS_HOLD(CAS_HOLD)) u_chain (
    .clk(clk), .rst(rst), .start(ch_start),
    .ras_act(ch_ras), .col_sel(ch_sel), .cas_act(ch_cas), .done(ch_done)
  );

  assign ref_ack  = (state == ST_IDLE) && ref_due;
  assign ch_start = (state == ST_IDLE) && !ref_due && (pend || req);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cap     <= '0;
      pend    <= 1'b0;
      rdy_q   <= 1'b1;
      ref_ras <= 1'b0;
      ref_cnt <= '0;
      row_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ref_due) begin
            state   <= ST_REF;
            ref_ras <= 1'b1;
            ref_cnt <= '0;
            if (req && !pend) begin
              pend  <= 1'b1;
              cap   <= addr;
              rdy_q <= 1'b0;
            end
          end else if (pend) begin
            state <= ST_ACC;
            pend  <= 1'b0;
            rdy_q <= 1'b1;
          end else if (req) begin
            state <= ST_ACC;
            cap   <= addr;
          end
        end
        ST_ACC: begin
          if (ch_done) state <= ST_IDLE;
        end
        ST_REF: begin
          ref_cnt <= ref_cnt + 1'b1;
          if (req && !pend) begin
            pend  <= 1'b1;
            cap   <= addr;
            rdy_q <= 1'b0;
          end
          if (ref_cnt == RW'(REF_RAS - 1)) begin
            ref_ras <= 1'b0;
            row_cnt <= row_cnt + 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ready     = rdy_q;
  assign ras_n     = ~(ch_ras | ref_ras);
  assign cas_n     = ~ch_cas;
  assign dram_addr = ref_ras ? row_cnt : (ch_sel ? cap[ROW_W-1:0] : cap[AW-1:ROW_W]);
endmodule

// File: rtl/dram_addr_seq_chk.sv
module dram_addr_seq_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ready,
  input logic [ROW_W-1:0] dram_addr,
  input logic             ras_n,
  input logic             cas_n
);
  // R4: column strobe only inside an active row strobe
  a_r4_cas_inside_ras: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);

  // R4: the two strobes end an access at the same edge
  a_r4_rise_together: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> $rose(ras_n));

  // R3: column strobe falls on an address already switched under a low row strobe
  a_r3_cas_on_stable_col: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> ($stable(dram_addr) && $past(!ras_n)));

  // R4: address held while the column strobe stays low
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));

  // R8: no column strobe while a request is held off
  a_r8_wait_no_cas: assert property (@(posedge clk) disable iff (rst)
    !ready |-> cas_n);
endmodule

bind dram_addr_seq dram_addr_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .dram_addr(dram_addr),
  .ras_n(ras_n), .cas_n(cas_n)
);

// File: tb/tb_dram_addr_seq.sv
module tb_dram_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P          = 40;
  localparam int RAS_R      = 3;
  localparam int HOLD       = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [15:0] addr = '0;
  logic        ready;
  logic [7:0]  dram_addr;
  logic        ras_n, cas_n;

  int n_run  = 0;
  int n_fail = 0;
  int exp_row = 0;

  dram_addr_seq #(.ROW_W(8), .REF_PERIOD(P), .REF_RAS(RAS_R), .CAS_HOLD(HOLD)) dut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .ready(ready),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drives one request and checks the whole access, returns after strobes rise
  task automatic run_access(input logic [15:0] a, input string tag);
    req = 1'b1; addr = a;
    @(negedge clk); req = 1'b0;
    chk({tag, " R2 ras low"}, ras_n, 0);
    chk({tag, " R2 row addr"}, dram_addr, a[15:8]);
    @(negedge clk);
    chk({tag, " R3 col addr"}, dram_addr, a[7:0]);
    chk({tag, " R3 cas still high"}, cas_n, 1);
    @(negedge clk);
    chk({tag, " R4 cas low"}, cas_n, 0);
    for (int i = 1; i < HOLD; i++) begin
      @(negedge clk);
      chk({tag, " R4 cas held"}, cas_n, 0);
      chk({tag, " R4 addr held"}, dram_addr, a[7:0]);
    end
    @(negedge clk);
    chk({tag, " R4 strobes up"}, {ras_n, cas_n}, 2'b11);
    chk({tag, " ready"}, ready, 1);
  endtask

  task automatic wait_refresh(input string tag);
    while (ras_n !== 1'b0) @(negedge clk);
    chk({tag, " R6 refresh cas high"}, cas_n, 1);
    chk({tag, " R6 refresh row"}, dram_addr, exp_row[7:0]);
    for (int i = 1; i < RAS_R; i++) begin
      @(negedge clk);
      chk({tag, " R6 refresh ras held"}, ras_n, 0);
    end
    @(negedge clk);
    chk({tag, " R6 refresh end"}, ras_n, 1);
    exp_row++;
  endtask

  task automatic t_reset;
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 ready", ready, 1);
  endtask

  task automatic t_basic;
    run_access(16'hA35C, "basic1");
    @(negedge clk);
    run_access(16'h01FE, "basic2");
  endtask

  task automatic t_ignore;
    req = 1'b1; addr = 16'h7C12;
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    req = 1'b1; addr = 16'hEEEE;
    @(negedge clk); req = 1'b0;
    chk("R5 addr kept", dram_addr, 8'h12);
    chk("R5 cas low", cas_n, 0);
    @(negedge clk);
    @(negedge clk);
    chk("R5 access ended", ras_n, 1);
    @(negedge clk);
    chk("R5 no second access", ras_n, 1);
    chk("R5 no second cas", cas_n, 1);
  endtask

  task automatic t_hold_off;
    while (ras_n !== 1'b0) @(negedge clk);
    req = 1'b1; addr = 16'h5A3B;
    @(negedge clk); req = 1'b0;
    chk("R8 ready low", ready, 0);
    chk("R8 refresh row", dram_addr, exp_row[7:0]);
    @(negedge clk);
    chk("R8 ready still low", ready, 0);
    @(negedge clk);
    chk("R8 refresh ended", ras_n, 1);
    chk("R8 ready low at refresh end", ready, 0);
    exp_row++;
    @(negedge clk);
    chk("R8 ready back", ready, 1);
    chk("R8 held access ras", ras_n, 0);
    chk("R8 held row", dram_addr, 8'h5A);
    @(negedge clk);
    chk("R8 held col", dram_addr, 8'h3B);
    repeat (HOLD + 2) @(negedge clk);
    chk("R8 access done", ras_n, 1);
  endtask

  task automatic t_defer;
    wait_refresh("defer pre");
    repeat (P - 6) @(negedge clk);
    run_access(16'hC3D4, "R7 access");
    @(negedge clk);
    chk("R7 refresh after access", ras_n, 0);
    chk("R7 refresh cas high", cas_n, 1);
    chk("R7 refresh row", dram_addr, exp_row[7:0]);
    exp_row++;
    repeat (RAS_R) @(negedge clk);
    chk("R7 refresh done", ras_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_basic();
    @(negedge clk);
    t_ignore();
    wait_refresh("R6 first");
    wait_refresh("R6 second");
    t_hold_off();
    t_defer();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule